// File: doc/BRIEF.md
# Video RAM Copy Engine (General and Blanking Modes)

This block copies data into the 8 KiB video RAM window at 0x8000 in 16-byte units. Software loads a source address, a destination address and a control byte through a small register port. The control byte picks one of two modes.

In general mode the whole length is copied at once, and the CPU is held off for the whole copy. In blanking mode one 16-byte unit is copied at each horizontal-blank start while the display is on. Copying continues until the remaining-unit count runs out.

Each byte takes two clocks on a simple master port: a read from the source, then a write of that byte to the destination. A stall output is held high for the length of every burst. When a burst ends, the address registers read back the advanced source and destination. The control register then reports the remaining count or the idle code.

Top module: `vdma_top`

## Requirements
- R1: After reset the control register (register address 4) reads 0xFF, the address registers (addresses 0 source high, 1 source low, 2 destination high, 3 destination low) read 0x00, and `cpu_stall`, `m_rd_en` and `m_wr_en` are low.
- R2: A burst reads from the source with its low 4 bits cleared. It writes to 0x8000 OR'd with destination bits 12:4. The destination wraps inside 0x8000–0x9FFF.
- R3: A control write while the aligned source lies in 0x8000–0x9FFF starts no copy, and the control register then reads back the written value with bit 7 set. A source of 0xA000 is accepted.
- R4: A control write with bit 7 clear, made while no blanking copy is pending, copies (bits 6:0 + 1) × 16 bytes at once. Each destination byte equals the source byte.
- R5: Each byte is a one-cycle read followed by a one-cycle write. `cpu_stall` is high for exactly 2 cycles per byte, starting the cycle after the control write or the blank start.
- R6: After a burst the four address registers hold the source and destination just past the last byte copied.
- R7: When a general copy ends, the control register reads 0xFF.
- R8: A control write with bit 7 set, made while the display is on and the video mode is not 0, copies nothing and reads back the value with bit 7 cleared. Each later `hblank_start` then copies 16 bytes and decrements the control register. Once the register reaches 0xFF, blanking mode stops and further blank starts copy nothing.
- R9: A blanking-mode control write made while the display is on and the video mode is 0 copies 16 bytes at once.
- R10: A blanking-mode control write made with the display off copies nothing. It reads back bit 7 set, with bits 6:0 equal to (value + 1) mod 128.
- R11: Register writes made while a burst runs are ignored. `hblank_start` outside blanking mode starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register select (0–4) |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data for `cfg_addr` |
| lcd_on | input | 1 | Display enabled |
| vid_mode | input | 2 | Current video mode |
| hblank_start | input | 1 | One-cycle pulse at horizontal-blank start |
| m_rd_en | output | 1 | Master read strobe |
| m_wr_en | output | 1 | Master write strobe |
| m_addr | output | 16 | Master address |
| m_wdata | output | 8 | Master write data |
| m_rdata | input | 8 | Master read data, valid one cycle after `m_rd_en` |
| cpu_stall | output | 1 | CPU hold while a burst runs |

## Verification
The bench builds the block with its default unit size of 16 bytes. At that size the bench can reach bursts of 16 to 64 bytes. It can also exercise a destination that wraps from 0x9FFF to 0x8000, the rejection boundaries at 0x9FFF and 0xA000, and a three-unit blanking sequence that decrements down to the idle code. The length field is kept small, so every case finishes in a few hundred cycles. Even so, each case covers the read, the write-back of the addresses and the update of the control register.

// File: rtl/vdma_pkg.sv
package vdma_pkg;

    localparam logic [15:0] VRAM_BASE = 16'h8000;
    localparam logic [15:0] VRAM_WIN  = 16'h1FFF;
    localparam logic [7:0]  CTRL_IDLE = 8'hFF;

    typedef enum logic [2:0] {
        REG_SRC_HI = 3'd0,
        REG_SRC_LO = 3'd1,
        REG_DST_HI = 3'd2,
        REG_DST_LO = 3'd3,
        REG_CTRL   = 3'd4
    } reg_sel_e;

    typedef enum logic [1:0] {
        ENG_IDLE  = 2'd0,
        ENG_READ  = 2'd1,
        ENG_WRITE = 2'd2
    } eng_state_e;

    typedef struct packed {
        logic        blank;
        logic [6:0]  count;
    } ctrl_word_t;

    function automatic logic in_vram(input logic [15:0] a);
        return a[15:13] == VRAM_BASE[15:13];
    endfunction

    function automatic logic [15:0] wrap_dst(input logic [15:0] a);
        return VRAM_BASE | (a & VRAM_WIN);
    endfunction

    function automatic logic [7:0] pending_code(input logic [7:0] v);
        logic [7:0] inc;
        inc = v + 8'd1;
        return {1'b1, inc[6:0]};
    endfunction

endpackage

// File: rtl/vdma_regs.sv
module vdma_regs
    import vdma_pkg::*;
#(
    parameter int UNIT_LOG2 = 4,
    parameter int CNT_W     = 7 + UNIT_LOG2 + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [2:0]       cfg_addr,
    input  logic [7:0]       cfg_wdata,
    output logic [7:0]       cfg_rdata,
    input  logic             lcd_on,
    input  logic [1:0]       vid_mode,
    input  logic             hblank_start,
    input  logic             busy,
    input  logic             done,
    input  logic [15:0]      end_src,
    input  logic [15:0]      end_dst,
    output logic             start,
    output logic [15:0]      start_src,
    output logic [15:0]      start_dst,
    output logic [CNT_W-1:0] start_len
);
    localparam logic [15:0] LOW_MASK = 16'((1 << UNIT_LOG2) - 1);
    localparam logic [CNT_W-1:0] UNIT_LEN = CNT_W'(1) << UNIT_LOG2;

    logic [7:0]  addr_q [4];
    logic [7:0]  ctrl_q;
    logic        blank_on_q;

    logic [15:0] src_al;
    logic [15:0] dst_al;
    ctrl_word_t  wv;
    logic        ctrl_wr;
    logic        reject;
    logic        go_now;
    logic        hb_go;
    logic [7:0]  ctrl_dec;
    logic [CNT_W-1:0] units;

    assign wv      = ctrl_word_t'(cfg_wdata);
    assign src_al  = {addr_q[0], addr_q[1]} & ~LOW_MASK;
    assign dst_al  = wrap_dst({addr_q[2], addr_q[3]} & ~LOW_MASK);
    assign ctrl_wr = cfg_we && !busy && (cfg_addr == REG_CTRL);
    assign reject  = in_vram(src_al);
    assign go_now  = ctrl_wr && !reject &&
                     ((!blank_on_q && !wv.blank) || (lcd_on && vid_mode == 2'd0));
    assign hb_go   = !busy && !ctrl_wr && blank_on_q && lcd_on && hblank_start;
    assign ctrl_dec = ctrl_q - 8'd1;
    assign units   = CNT_W'(wv.count) + CNT_W'(1);

    always_comb begin
        start     = go_now || hb_go;
        start_src = src_al;
        start_dst = dst_al;
        if (go_now && !wv.blank) begin
            start_len = units << UNIT_LOG2;
        end else begin
            start_len = UNIT_LEN;
        end
    end

    always_comb begin
        unique case (cfg_addr)
            REG_SRC_HI: cfg_rdata = addr_q[0];
            REG_SRC_LO: cfg_rdata = addr_q[1];
            REG_DST_HI: cfg_rdata = addr_q[2];
            REG_DST_LO: cfg_rdata = addr_q[3];
            REG_CTRL:   cfg_rdata = ctrl_q;
            default:    cfg_rdata = CTRL_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 4; i++) begin
                addr_q[i] <= 8'h00;
            end
            ctrl_q     <= CTRL_IDLE;
            blank_on_q <= 1'b0;
        end else if (done) begin
            addr_q[0] <= end_src[15:8];
            addr_q[1] <= end_src[7:0];
            addr_q[2] <= end_dst[15:8];
            addr_q[3] <= end_dst[7:0];
            if (blank_on_q) begin
                ctrl_q <= ctrl_dec;
                if (ctrl_dec == CTRL_IDLE) begin
                    blank_on_q <= 1'b0;
                end
            end else begin
                ctrl_q <= CTRL_IDLE;
            end
        end else if (cfg_we && !busy) begin
            if (cfg_addr == REG_CTRL) begin
                if (reject) begin
                    ctrl_q <= cfg_wdata | 8'h80;
                end else begin
                    blank_on_q <= wv.blank;
                    if (wv.blank && !lcd_on) begin
                        ctrl_q <= pending_code(cfg_wdata);
                    end else begin
                        ctrl_q <= {1'b0, wv.count};
                    end
                end
            end else if (cfg_addr < 3'd4) begin
                addr_q[cfg_addr[1:0]] <= cfg_wdata;
            end
        end
    end

endmodule

// File: rtl/vdma_engine.sv
module vdma_engine
    import vdma_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [15:0]      start_src,
    input  logic [15:0]      start_dst,
    input  logic [CNT_W-1:0] start_len,
    output logic             busy,
    output logic             done,
    output logic [15:0]      end_src,
    output logic [15:0]      end_dst,
    output logic             m_rd_en,
    output logic             m_wr_en,
    output logic [15:0]      m_addr,
    output logic [7:0]       m_wdata,
    input  logic [7:0]       m_rdata
);
    eng_state_e       state_q;
    logic [15:0]      src_q;
    logic [15:0]      dst_q;
    logic [CNT_W-1:0] rem_q;
    logic [15:0]      src_nxt;
    logic [15:0]      dst_nxt;
    logic             last;

    assign src_nxt = src_q + 16'd1;
    assign dst_nxt = wrap_dst(dst_q + 16'd1);
    assign last    = (rem_q == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ENG_IDLE;
            src_q   <= 16'h0000;
            dst_q   <= VRAM_BASE;
            rem_q   <= '0;
        end else begin
            unique case (state_q)
                ENG_IDLE: begin
                    if (start) begin
                        src_q   <= start_src;
                        dst_q   <= start_dst;
                        rem_q   <= start_len;
                        state_q <= ENG_READ;
                    end
                end
                ENG_READ: begin
                    state_q <= ENG_WRITE;
                end
                ENG_WRITE: begin
                    src_q   <= src_nxt;
                    dst_q   <= dst_nxt;
                    rem_q   <= rem_q - CNT_W'(1);
                    state_q <= last ? ENG_IDLE : ENG_READ;
                end
                default: begin
                    state_q <= ENG_IDLE;
                end
            endcase
        end
    end

    always_comb begin
        busy    = (state_q != ENG_IDLE);
        m_rd_en = (state_q == ENG_READ);
        m_wr_en = (state_q == ENG_WRITE);
        m_addr  = m_wr_en ? dst_q : src_q;
        m_wdata = m_rdata;
        done    = m_wr_en && last;
        end_src = src_nxt;
        end_dst = dst_nxt;
    end

endmodule

// File: rtl/vdma_top.sv
module vdma_top
    import vdma_pkg::*;
#(
    parameter int UNIT_LOG2 = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_we,
    input  logic [2:0]  cfg_addr,
    input  logic [7:0]  cfg_wdata,
    output logic [7:0]  cfg_rdata,
    input  logic        lcd_on,
    input  logic [1:0]  vid_mode,
    input  logic        hblank_start,
    output logic        m_rd_en,
    output logic        m_wr_en,
    output logic [15:0] m_addr,
    output logic [7:0]  m_wdata,
    input  logic [7:0]  m_rdata,
    output logic        cpu_stall
);
    localparam int CNT_W = 7 + UNIT_LOG2 + 1;

    logic             busy;
    logic             done;
    logic [15:0]      end_src;
    logic [15:0]      end_dst;
    logic             start;
    logic [15:0]      start_src;
    logic [15:0]      start_dst;
    logic [CNT_W-1:0] start_len;

    vdma_regs #(.UNIT_LOG2(UNIT_LOG2), .CNT_W(CNT_W)) regs_i (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata),
        .lcd_on(lcd_on), .vid_mode(vid_mode), .hblank_start(hblank_start),
        .busy(busy), .done(done), .end_src(end_src), .end_dst(end_dst),
        .start(start), .start_src(start_src), .start_dst(start_dst),
        .start_len(start_len)
    );

    vdma_engine #(.CNT_W(CNT_W)) eng_i (
        .clk(clk), .rst(rst),
        .start(start), .start_src(start_src), .start_dst(start_dst),
        .start_len(start_len),
        .busy(busy), .done(done), .end_src(end_src), .end_dst(end_dst),
        .m_rd_en(m_rd_en), .m_wr_en(m_wr_en), .m_addr(m_addr),
        .m_wdata(m_wdata), .m_rdata(m_rdata)
    );

    assign cpu_stall = busy;

endmodule

// File: rtl/vdma_chk.sv
module vdma_chk #(
    parameter int UNIT_LOG2 = 4
) (
    input logic        clk,
    input logic        rst,
    input logic        m_rd_en,
    input logic        m_wr_en,
    input logic [15:0] m_addr,
    input logic        cpu_stall
);
    localparam logic [15:0] LOW_MASK = 16'((1 << UNIT_LOG2) - 1);

    // R5: a read is always followed by its write
    p_read_then_write_r5: assert property (@(posedge clk) disable iff (rst)
        m_rd_en |=> m_wr_en);

    // R5: no two writes back to back
    p_single_write_r5: assert property (@(posedge clk) disable iff (rst)
        m_wr_en |=> !m_wr_en);

    // R5: never both strobes
    p_one_strobe_r5: assert property (@(posedge clk) disable iff (rst)
        $onehot0({m_rd_en, m_wr_en}));

    // R5: a burst opens with a read
    p_stall_opens_read_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(cpu_stall) |-> m_rd_en);

    // R2: writes stay inside the video window
    p_dest_window_r2: assert property (@(posedge clk) disable iff (rst)
        m_wr_en |-> (m_addr[15:13] == 3'b100));

    // R2: first read of a burst is unit aligned
    p_src_aligned_r2: assert property (@(posedge clk) disable iff (rst)
        (m_rd_en && !$past(cpu_stall)) |-> ((m_addr & LOW_MASK) == 16'h0000));

    // R3: no burst starts from the video window
    p_src_not_vram_r3: assert property (@(posedge clk) disable iff (rst)
        (m_rd_en && !$past(cpu_stall)) |-> (m_addr[15:13] != 3'b100));

    // R11: master port quiet while not stalling
    p_quiet_idle_r11: assert property (@(posedge clk) disable iff (rst)
        !cpu_stall |-> !(m_rd_en || m_wr_en));

endmodule

bind vdma_top vdma_chk #(.UNIT_LOG2(UNIT_LOG2)) chk_i (
    .clk(clk), .rst(rst), .m_rd_en(m_rd_en), .m_wr_en(m_wr_en),
    .m_addr(m_addr), .cpu_stall(cpu_stall)
);

// File: tb/vdma_top_tb_top.sv
`timescale 1ns/1ps
module vdma_top_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = 3'd0;
    logic [7:0]  cfg_wdata = 8'h00;
    logic [7:0]  cfg_rdata;
    logic        lcd_on = 1'b0;
    logic [1:0]  vid_mode = 2'd0;
    logic        hblank_start = 1'b0;
    logic        m_rd_en;
    logic        m_wr_en;
    logic [15:0] m_addr;
    logic [7:0]  m_wdata;
    logic [7:0]  m_rdata = 8'h00;
    logic        cpu_stall;

    int checks = 0;
    int failures = 0;
    int stall_cycles = 0;
    int cycle_count = 0;
    logic [7:0] vram [0:8191];

    always #2.5 clk = ~clk;

    vdma_top dut_i (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .lcd_on(lcd_on),
        .vid_mode(vid_mode), .hblank_start(hblank_start),
        .m_rd_en(m_rd_en), .m_wr_en(m_wr_en), .m_addr(m_addr),
        .m_wdata(m_wdata), .m_rdata(m_rdata), .cpu_stall(cpu_stall)
    );

    function automatic logic [7:0] pat(input logic [15:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h3C;
    endfunction

    always @(posedge clk) begin
        cycle_count <= cycle_count + 1;
        if (m_rd_en) m_rdata <= pat(m_addr);
        if (m_wr_en) vram[m_addr[12:0]] <= m_wdata;
        if (cpu_stall) stall_cycles <= stall_cycles + 1;
    end

    always @(posedge clk) begin
        if (cycle_count > 150000) begin
            failures = failures + 1;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            failures = failures + 1;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        cfg_we = 1'b0;
        hblank_start = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        stall_cycles = 0;
        for (int i = 0; i < 8192; i++) vram[i] = 8'h00;
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [7:0] v);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_addr = a;
        cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [7:0] v);
        @(negedge clk);
        cfg_addr = a;
        #1 v = cfg_rdata;
    endtask

    task automatic pulse_hblank();
        @(negedge clk);
        hblank_start = 1'b1;
        @(negedge clk);
        hblank_start = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 5000 && cpu_stall; i++) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic set_addrs(input logic [15:0] s, input logic [15:0] d);
        wr_reg(3'd0, s[15:8]);
        wr_reg(3'd1, s[7:0]);
        wr_reg(3'd2, d[15:8]);
        wr_reg(3'd3, d[7:0]);
    endtask

    task automatic check_data(input logic [15:0] s, input logic [15:0] d,
                              input int n, input string req);
        int bad = 0;
        logic [12:0] idx;
        for (int i = 0; i < n; i++) begin
            idx = 13'(d + 16'(i));
            if (vram[idx] !== pat(s + 16'(i))) bad = bad + 1;
        end
        check(bad == 0, req, bad, 0);
    endtask

    task automatic check_reg16(input logic [2:0] hi, input logic [15:0] exp, input string req);
        logic [7:0] h;
        logic [7:0] l;
        rd_reg(hi, h);
        rd_reg(hi + 3'd1, l);
        check({h, l} == exp, req, {h, l}, exp);
    endtask

    // {src, dst, ctrl}
    localparam logic [39:0] VEC [4] = '{
        {16'h1234, 16'hA567, 8'h01},
        {16'h4000, 16'h0000, 8'h00},
        {16'hC0FF, 16'h1FF0, 8'h01},
        {16'hE0A7, 16'h0040, 8'h03}
    };

    initial begin
        logic [7:0] r;
        logic [15:0] s_al;
        logic [15:0] d_al;
        int n;

        // R1 reset state
        do_reset();
        rd_reg(3'd4, r);
        check(r == 8'hFF, "R1 ctrl", r, 8'hFF);
        check_reg16(3'd0, 16'h0000, "R1 src");
        check(!cpu_stall && !m_rd_en && !m_wr_en, "R1 idle", cpu_stall, 0);

        // R4 R5 R6 R7 R2: table of general transfers
        foreach (VEC[k]) begin
            do_reset();
            set_addrs(VEC[k][39:24], VEC[k][23:8]);
            s_al = VEC[k][39:24] & 16'hFFF0;
            d_al = 16'h8000 | (VEC[k][23:8] & 16'h1FF0);
            n = (int'(VEC[k][6:0]) + 1) * 16;
            wr_reg(3'd4, VEC[k][7:0]);
            wait_idle();
            check(stall_cycles == 2 * n, "R5 stall cycles", stall_cycles, 2 * n);
            check_data(s_al, d_al, n, "R4 R2 copied data");
            rd_reg(3'd4, r);
            check(r == 8'hFF, "R7 ctrl idle", r, 8'hFF);
            check_reg16(3'd0, s_al + 16'(n), "R6 src advanced");
            check_reg16(3'd2, 16'h8000 | ((d_al + 16'(n)) & 16'h1FFF), "R6 R2 dst advanced");
        end

        // R3 rejected sources
        do_reset();
        set_addrs(16'h8800, 16'h0000);
        wr_reg(3'd4, 8'h05);
        repeat (4) @(negedge clk);
        rd_reg(3'd4, r);
        check(r == 8'h85, "R3 reject readback", r, 8'h85);
        check(stall_cycles == 0, "R3 no copy", stall_cycles, 0);
        do_reset();
        set_addrs(16'h9FFF, 16'h0000);
        wr_reg(3'd4, 8'h00);
        repeat (4) @(negedge clk);
        check(stall_cycles == 0, "R3 no copy 9FFF", stall_cycles, 0);
        do_reset();
        set_addrs(16'hA000, 16'h0000);
        wr_reg(3'd4, 8'h00);
        wait_idle();
        check(stall_cycles == 32, "R3 A000 accepted", stall_cycles, 32);

        // R10 blanking request with display off
        do_reset();
        lcd_on = 1'b0;
        set_addrs(16'h2000, 16'h0200);
        wr_reg(3'd4, 8'h82);
        repeat (4) @(negedge clk);
        rd_reg(3'd4, r);
        check(r == 8'h83, "R10 readback", r, 8'h83);
        check(stall_cycles == 0, "R10 no copy", stall_cycles, 0);
        do_reset();
        wr_reg(3'd4, 8'hFF);
        rd_reg(3'd4, r);
        check(r == 8'h80, "R10 readback wrap", r, 8'h80);

        // R11 blank start outside blanking mode
        do_reset();
        lcd_on = 1'b1;
        vid_mode = 2'd0;
        pulse_hblank();
        repeat (4) @(negedge clk);
        check(stall_cycles == 0, "R11 hblank ignored", stall_cycles, 0);

        // R8 blanking sequence
        do_reset();
        lcd_on = 1'b1;
        vid_mode = 2'd1;
        set_addrs(16'h2000, 16'h0200);
        wr_reg(3'd4, 8'h82);
        repeat (3) @(negedge clk);
        rd_reg(3'd4, r);
        check(r == 8'h02, "R8 armed readback", r, 8'h02);
        check(stall_cycles == 0, "R8 no immediate copy", stall_cycles, 0);
        pulse_hblank();
        wait_idle();
        check(stall_cycles == 32, "R8 first burst", stall_cycles, 32);
        rd_reg(3'd4, r);
        check(r == 8'h01, "R8 decrement", r, 8'h01);
        check_reg16(3'd0, 16'h2010, "R6 R8 src after burst");
        pulse_hblank();
        wait_idle();
        pulse_hblank();
        wait_idle();
        rd_reg(3'd4, r);
        check(r == 8'hFF, "R8 reaches idle", r, 8'hFF);
        check(stall_cycles == 96, "R8 three bursts", stall_cycles, 96);
        check_data(16'h2000, 16'h8200, 48, "R8 blank data");
        pulse_hblank();
        wait_idle();
        check(stall_cycles == 96, "R8 mode ended", stall_cycles, 96);

        // R9 blanking request during mode 0
        do_reset();
        lcd_on = 1'b1;
        vid_mode = 2'd0;
        set_addrs(16'h5000, 16'h0300);
        wr_reg(3'd4, 8'h83);
        wait_idle();
        check(stall_cycles == 32, "R9 immediate burst", stall_cycles, 32);
        rd_reg(3'd4, r);
        check(r == 8'h02, "R9 ctrl after burst", r, 8'h02);
        check_data(16'h5000, 16'h8300, 16, "R9 data");

        // R11 writes during a burst ignored
        do_reset();
        lcd_on = 1'b0;
        set_addrs(16'h3000, 16'h0100);
        wr_reg(3'd4, 8'h00);
        wr_reg(3'd0, 8'h55);
        wr_reg(3'd4, 8'h7F);
        wait_idle();
        check(stall_cycles == 32, "R11 busy ctrl write ignored", stall_cycles, 32);
        check_reg16(3'd0, 16'h3010, "R11 busy src write ignored");
        rd_reg(3'd4, r);
        check(r == 8'hFF, "R11 ctrl after", r, 8'hFF);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule